// File: doc/BRIEF.md
# Windowed Video Frame CRC Engine

This block produces a signature of each video frame that passes through it. It computes one CRC per colour channel (R/Cr, G/Y, B/Cb). Only the pixels that a programmable combination of two rectangles selects count towards the signature. Pixels arrive as a stream, each carrying a valid qualifier, three 10-bit components, a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of every row. The engine counts column and row itself from those two flags.

Software writes a configuration word: two rectangles, a 3-bit combination code, an enable and a repeat mode. The engine accepts the word only while the timing path reports it is running. An accepted word waits and becomes active at the next start-of-frame. A frame that the engine computes ends when the next start-of-frame arrives. At that moment the three signatures move into holding registers, a one-cycle done pulse is raised, and the read side reports valid. A flag marks the first frame after enabling as one that should be discarded.

Top module: `frame_crc_engine`

## Requirements
- R1: A pixel at column x, row y lies inside a rectangle when x0 <= x < x1 and y0 <= y < y1. The start-of-frame pixel is (0,0). Each valid pixel advances the column by one. A valid pixel carrying end-of-line returns the column to 0 and advances the row by one.
- R2: With A and B meaning membership in the two rectangles, cfg_sel selects the qualifying set. Bit 2 = 0 means OR and bit 2 = 1 means AND. Bit 1 inverts A and bit 0 inverts B. So code 0 is A|B, 1 is A|!B, 2 is !A|B, 3 is !A|!B, and codes 4 to 7 are the same four with AND.
- R3: Each channel signature is CRC-32 with polynomial 0x04C11DB7. It is seeded with all ones at start-of-frame and takes the 10-bit component MSB first, with no reflection and no final inversion. Cycles with pix_valid low change nothing, whatever the other pixel inputs carry. Pixels that do not qualify change nothing.
- R4: With both rectangles spanning the whole active area and code 0, every pixel of the frame contributes.
- R5: A computed frame ends at the next start-of-frame pixel. In the cycle after that pixel, crc_done is high for one cycle and crc_r/crc_g/crc_b hold that frame's signatures. The outputs stay unchanged until the next crc_done.
- R6: In repeat mode (cfg_continuous = 1) every frame is computed and reported.
- R7: In single mode (cfg_continuous = 0) exactly one frame is computed after the configuration takes effect. Later frames produce no crc_done and leave the results unchanged.
- R8: rd_valid is low after reset and becomes high with the first crc_done. It goes low at the start-of-frame where a configuration with cfg_enable = 0 takes effect.
- R9: A cfg_write while timing_active is low raises cfg_error in the next cycle and leaves the configuration unchanged. A write while timing_active is high leaves cfg_error low.
- R10: An accepted configuration takes effect only at the next start-of-frame. The frame in progress completes with the old settings.
- R11: crc_suspect, updated with crc_done, is high for the first frame computed after an enabling configuration takes effect, and low for the frames that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_active | input | 1 | Timing path is running; configuration is accepted only while high |
| cfg_write | input | 1 | Configuration write strobe |
| cfg_a_x0 | input | 16 | Rectangle A first column |
| cfg_a_x1 | input | 16 | Rectangle A column bound (exclusive) |
| cfg_a_y0 | input | 16 | Rectangle A first row |
| cfg_a_y1 | input | 16 | Rectangle A row bound (exclusive) |
| cfg_b_x0 | input | 16 | Rectangle B first column |
| cfg_b_x1 | input | 16 | Rectangle B column bound (exclusive) |
| cfg_b_y0 | input | 16 | Rectangle B first row |
| cfg_b_y1 | input | 16 | Rectangle B row bound (exclusive) |
| cfg_sel | input | 3 | Rectangle combination code |
| cfg_enable | input | 1 | Capture enable |
| cfg_continuous | input | 1 | 1 = every frame, 0 = one frame |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| pix_r | input | 10 | R/Cr component |
| pix_g | input | 10 | G/Y component |
| pix_b | input | 10 | B/Cb component |
| cfg_error | output | 1 | Write refused (one cycle) |
| crc_done | output | 1 | New results available (one cycle) |
| crc_suspect | output | 1 | Held result is the first after enabling |
| rd_valid | output | 1 | Held results are valid |
| crc_r | output | 32 | R/Cr signature |
| crc_g | output | 32 | G/Y signature |
| crc_b | output | 32 | B/Cb signature |

## Verification
Most internal faults show up only as a wrong signature, and that signature comes out in the crc_done cycle that follows the next start-of-frame. The faults include a miscounted column or row, a wrong inversion or combination, a bad CRC step, and a configuration applied in the wrong frame. The bench therefore predicts every result frame by frame and compares it when the pulse arrives. A wrong one-shot or enable state shows as a missing or an extra crc_done within one frame. Wrong refusal logic shows as a wrong cfg_error the cycle after the write, and also as a wrong signature one frame later.

// File: rtl/frame_crc_engine.sv
module frame_crc_engine #(
  parameter int CW = 16,
  parameter int DW = 10,
  parameter int RW = 32,
  parameter logic [RW-1:0] POLY = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          timing_active,
  input  logic          cfg_write,
  input  logic [CW-1:0] cfg_a_x0,
  input  logic [CW-1:0] cfg_a_x1,
  input  logic [CW-1:0] cfg_a_y0,
  input  logic [CW-1:0] cfg_a_y1,
  input  logic [CW-1:0] cfg_b_x0,
  input  logic [CW-1:0] cfg_b_x1,
  input  logic [CW-1:0] cfg_b_y0,
  input  logic [CW-1:0] cfg_b_y1,
  input  logic [2:0]    cfg_sel,
  input  logic          cfg_enable,
  input  logic          cfg_continuous,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic [DW-1:0] pix_r,
  input  logic [DW-1:0] pix_g,
  input  logic [DW-1:0] pix_b,
  output logic          cfg_error,
  output logic          crc_done,
  output logic          crc_suspect,
  output logic          rd_valid,
  output logic [RW-1:0] crc_r,
  output logic [RW-1:0] crc_g,
  output logic [RW-1:0] crc_b
);
  localparam int CFGW = 8*CW + 5;

  function automatic logic [RW-1:0] crc_step(input logic [RW-1:0] c_in, input logic [DW-1:0] d);
    logic [RW-1:0] c;
    logic fb;
    c = c_in;
    for (int i = DW-1; i >= 0; i--) begin
      fb = c[RW-1] ^ d[i];
      c  = {c[RW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [CFGW-1:0] shadow, active;
  logic            pend, armed, open, first;
  logic [CW-1:0]   x, y;
  logic [RW-1:0]   acc_r, acc_g, acc_b;

  wire [CFGW-1:0] cfg_in = {cfg_a_x0, cfg_a_x1, cfg_a_y0, cfg_a_y1,
                            cfg_b_x0, cfg_b_x1, cfg_b_y0, cfg_b_y1,
                            cfg_sel, cfg_enable, cfg_continuous};

  wire sof   = pix_valid & pix_sof;
  wire apply = sof & pend;
  wire [CFGW-1:0] cur = apply ? shadow : active;

  logic [CW-1:0] ax0, ax1, ay0, ay1, bx0, bx1, by0, by1;
  logic [2:0]    sel;
  logic          en, cont;
  assign {ax0, ax1, ay0, ay1, bx0, bx1, by0, by1, sel, en, cont} = cur;

  wire [CW-1:0] cx = sof ? '0 : x;
  wire [CW-1:0] cy = sof ? '0 : y;

  wire in_a = (cx >= ax0) && (cx < ax1) && (cy >= ay0) && (cy < ay1);
  wire in_b = (cx >= bx0) && (cx < bx1) && (cy >= by0) && (cy < by1);
  wire wa   = in_a ^ sel[1];
  wire wb   = in_b ^ sel[0];
  wire pass = sel[2] ? (wa & wb) : (wa | wb);

  wire arm_n  = apply ? en : armed;
  wire open_n = sof ? (en & (cont | arm_n)) : open;
  wire take   = pix_valid & open_n & pass;

  wire [RW-1:0] base_r = sof ? '1 : acc_r;
  wire [RW-1:0] base_g = sof ? '1 : acc_g;
  wire [RW-1:0] base_b = sof ? '1 : acc_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0; active <= '0;
      pend <= 1'b0; armed <= 1'b0; open <= 1'b0; first <= 1'b0;
      x <= '0; y <= '0;
      acc_r <= '1; acc_g <= '1; acc_b <= '1;
      crc_r <= '0; crc_g <= '0; crc_b <= '0;
      cfg_error <= 1'b0; crc_done <= 1'b0; crc_suspect <= 1'b0; rd_valid <= 1'b0;
    end else begin
      cfg_error <= cfg_write & ~timing_active;
      crc_done  <= sof & open;

      if (cfg_write && timing_active) begin
        shadow <= cfg_in;
        pend   <= 1'b1;
      end else if (apply) begin
        pend   <= 1'b0;
      end

      if (sof) begin
        if (open) begin
          crc_r <= acc_r; crc_g <= acc_g; crc_b <= acc_b;
          crc_suspect <= first;
          rd_valid    <= 1'b1;
        end
        if (apply) begin
          active <= shadow;
          if (!en) rd_valid <= 1'b0;
        end
        first <= apply & en;
        open  <= open_n;
        armed <= arm_n & ~(open_n & ~cont);
      end

      if (sof || take) begin
        acc_r <= take ? crc_step(base_r, pix_r) : '1;
        acc_g <= take ? crc_step(base_g, pix_g) : '1;
        acc_b <= take ? crc_step(base_b, pix_b) : '1;
      end

      if (pix_valid) begin
        if (pix_eol) begin
          x <= '0;
          y <= cy + 1'b1;
        end else begin
          x <= cx + 1'b1;
          y <= cy;
        end
      end
    end
  end
endmodule

// File: rtl/frame_crc_engine_sva.sv
module frame_crc_engine_sva #(parameter int RW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_sof,
  input logic          cfg_write,
  input logic          timing_active,
  input logic          cfg_error,
  input logic          crc_done,
  input logic          crc_suspect,
  input logic          rd_valid,
  input logic [RW-1:0] crc_r,
  input logic [RW-1:0] crc_g,
  input logic [RW-1:0] crc_b
);
  assert_done_after_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> $past(pix_valid && pix_sof));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> ($stable(crc_r) && $stable(crc_g) && $stable(crc_b)));

  assert_refuse_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write && !timing_active) |=> cfg_error);

  assert_error_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> $past(cfg_write && !timing_active));

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> crc_done);

  assert_suspect_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> $stable(crc_suspect));
endmodule

bind frame_crc_engine frame_crc_engine_sva #(.RW(RW)) u_sva (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .cfg_write(cfg_write), .timing_active(timing_active), .cfg_error(cfg_error),
  .crc_done(crc_done), .crc_suspect(crc_suspect), .rd_valid(rd_valid),
  .crc_r(crc_r), .crc_g(crc_g), .crc_b(crc_b)
);

// File: tb/frame_crc_engine_test.sv
module frame_crc_engine_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] ax0, ax1, ay0, ay1, bx0, bx1, by0, by1;
    logic [2:0]  sel;
    logic        en, cont;
  } cfg_t;

  logic clk = 1'b0, rst_n = 1'b0, timing_active = 1'b1, cfg_write = 1'b0;
  cfg_t cfg_drv = '0;
  logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
  logic [9:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic cfg_error, crc_done, crc_suspect, rd_valid;
  logic [31:0] crc_r, crc_g, crc_b;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_crc_engine uut (
    .clk(clk), .rst_n(rst_n), .timing_active(timing_active), .cfg_write(cfg_write),
    .cfg_a_x0(cfg_drv.ax0), .cfg_a_x1(cfg_drv.ax1), .cfg_a_y0(cfg_drv.ay0), .cfg_a_y1(cfg_drv.ay1),
    .cfg_b_x0(cfg_drv.bx0), .cfg_b_x1(cfg_drv.bx1), .cfg_b_y0(cfg_drv.by0), .cfg_b_y1(cfg_drv.by1),
    .cfg_sel(cfg_drv.sel), .cfg_enable(cfg_drv.en), .cfg_continuous(cfg_drv.cont),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .cfg_error(cfg_error), .crc_done(crc_done), .crc_suspect(crc_suspect), .rd_valid(rd_valid),
    .crc_r(crc_r), .crc_g(crc_g), .crc_b(crc_b)
  );

  // reference model state
  cfg_t m_sh = '0, m_act = '0;
  bit m_pend = 0, m_arm = 0, m_open = 0, m_first = 0, m_rdv = 0;
  logic [31:0] m_r, m_g, m_b;
  string cur_tag = "", m_tag = "";
  logic [96:0] exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [9:0] d);
    logic [31:0] c = c_in;
    for (int i = 9; i >= 0; i--) begin
      if (c[31] ^ d[i]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  function automatic bit qualifies(input cfg_t c, input int x, input int y);
    bit a, b;
    a = (x >= c.ax0) && (x < c.ax1) && (y >= c.ay0) && (y < c.ay1);
    b = (x >= c.bx0) && (x < c.bx1) && (y >= c.by0) && (y < c.by1);
    if (c.sel[1]) a = !a;
    if (c.sel[0]) b = !b;
    return c.sel[2] ? (a && b) : (a || b);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_cfg(input cfg_t c);
    @(negedge clk);
    pix_valid = 1'b0;
    cfg_drv   = c;
    cfg_write = 1'b1;
    @(negedge clk);
    cfg_write = 1'b0;
    check(cfg_error == !timing_active, "R9", "cfg_error", {31'b0, cfg_error}, {31'b0, !timing_active});
    if (timing_active) begin
      m_sh   = c;
      m_pend = 1;
    end
  endtask

  task automatic model_sof();
    bit apply;
    if (m_open) begin
      exp_q.push_back({m_first, m_r, m_g, m_b});
      tag_q.push_back(m_tag);
      m_rdv = 1;
    end
    apply = m_pend;
    if (apply) begin
      m_act  = m_sh;
      m_pend = 0;
      m_arm  = m_sh.en;
      if (!m_sh.en) m_rdv = 0;
    end
    m_first = apply && m_act.en;
    m_open  = m_act.en && (m_act.cont || m_arm);
    if (m_open && !m_act.cont) m_arm = 0;
    m_tag = cur_tag;
    m_r = '1; m_g = '1; m_b = '1;
  endtask

  task automatic send_frame(input int w, input int h, input int seed,
                            input bit mid, input cfg_t mc);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        logic [9:0] vr, vg, vb;
        if (mid && r == h/2 && c == 0) do_cfg(mc);
        if (r == 0 && c == 0) model_sof();
        vr = 10'((seed*37 + r*11 + c*5 + 3) % 1024);
        vg = 10'((seed*91 + r*29 + c*13 + 7) % 1024);
        vb = 10'((seed*53 + r*3 + c*17 + 500) % 1024);
        if (m_open && qualifies(m_act, c, r)) begin
          m_r = ref_crc(m_r, vr); m_g = ref_crc(m_g, vg); m_b = ref_crc(m_b, vb);
        end
        @(negedge clk);
        pix_valid = 1'b1;
        pix_sof   = (r == 0 && c == 0);
        pix_eol   = (c == w-1);
        pix_r = vr; pix_g = vg; pix_b = vb;
        if ((r + c + seed) % 5 == 4) begin
          @(negedge clk);
          pix_valid = 1'b0; pix_sof = 1'b1; pix_eol = 1'b1;
          pix_r = ~vr; pix_g = ~vg; pix_b = ~vb;
        end
      end
    end
    @(negedge clk);
    pix_valid = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_valid == m_rdv, "R8", "rd_valid", {31'b0, rd_valid}, {31'b0, m_rdv});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && crc_done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected crc_done actual=1 expected=0");
      end else begin
        logic [96:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(crc_r == e[95:64], {t, " R3 R5"}, "crc_r", crc_r, e[95:64]);
        check(crc_g == e[63:32], {t, " R3 R5"}, "crc_g", crc_g, e[63:32]);
        check(crc_b == e[31:0],  {t, " R3 R5"}, "crc_b", crc_b, e[31:0]);
        check(crc_suspect == e[96], "R11", "crc_suspect", {31'b0, crc_suspect}, {31'b0, e[96]});
      end
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_t full, win, c;
    logic [31:0] sr, sg, sb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_valid == 1'b0, "R8", "reset rd_valid", {31'b0, rd_valid}, 32'd0);
    check(crc_done == 1'b0, "R5", "reset crc_done", {31'b0, crc_done}, 32'd0);
    check(cfg_error == 1'b0, "R9", "reset cfg_error", {31'b0, cfg_error}, 32'd0);

    full = '{ax0:0, ax1:8, ay0:0, ay1:4, bx0:0, bx1:8, by0:0, by1:4, sel:3'd0, en:1'b1, cont:1'b1};
    cur_tag = "R4 R6";
    do_cfg(full);
    for (int f = 0; f < 3; f++) send_frame(8, 4, f + 1, 1'b0, full);

    win = '{ax0:2, ax1:6, ay0:1, ay1:3, bx0:4, bx1:8, by0:0, by1:2, sel:3'd0, en:1'b1, cont:1'b1};
    cur_tag = "R1 R2";
    for (int s = 0; s < 8; s++) begin
      c = win; c.sel = 3'(s);
      do_cfg(c);
      send_frame(8, 4, 10 + s, 1'b0, full);
      send_frame(8, 4, 20 + s, 1'b0, full);
    end

    c = win; c.ax0 = 7; c.ax1 = 8; c.ay0 = 3; c.ay1 = 4; c.sel = 3'd5;
    cur_tag = "R1 edge";
    do_cfg(c);
    send_frame(8, 4, 31, 1'b0, full);

    c = win; c.sel = 3'd6;
    cur_tag = "R10";
    send_frame(8, 4, 32, 1'b1, c);
    send_frame(8, 4, 33, 1'b0, full);

    timing_active = 1'b0;
    c = win; c.sel = 3'd3;
    cur_tag = "R9";
    do_cfg(c);
    timing_active = 1'b1;
    send_frame(8, 4, 34, 1'b0, full);
    send_frame(8, 4, 35, 1'b0, full);

    c = full; c.cont = 1'b0;
    cur_tag = "R7";
    do_cfg(c);
    for (int f = 0; f < 3; f++) send_frame(8, 4, 40 + f, 1'b0, full);
    sr = crc_r; sg = crc_g; sb = crc_b;
    send_frame(8, 4, 50, 1'b0, full);
    send_frame(6, 3, 51, 1'b0, full);
    check(crc_r == sr && crc_g == sg && crc_b == sb, "R7", "results held", crc_r, sr);
    check(rd_valid == 1'b1, "R8", "valid after one-shot", {31'b0, rd_valid}, 32'd1);

    c = full; c.en = 1'b0;
    cur_tag = "R8";
    do_cfg(c);
    send_frame(8, 4, 60, 1'b0, full);
    send_frame(8, 4, 61, 1'b0, full);
    check(rd_valid == 1'b0, "R8", "valid after disable", {31'b0, rd_valid}, 32'd0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5", "pending results", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule